// File: doc/BRIEF.md
# Two-Pass Montgomery Modular Multiplier

This block returns the true modular product A*B mod M for an odd modulus M. It uses a radix-2 Montgomery core that consumes one multiplier bit per iteration. A single Montgomery pass leaves a stray factor of 2^-W in its result. To remove it, the block runs the same core twice. The first pass turns A and B into P1 = A*B*2^-W mod M. The second pass multiplies P1 by a constant K = 2^(2W) mod M, and that constant's 2^W factors cancel the stray factor.

The caller computes K and supplies it. The caller holds A, B, M and K on the inputs for the cycle in which it raises `start`. The block copies them at that edge. When the product is ready the block gives a one-cycle `done` pulse. The product then stays on `product` until the next product replaces it.

Top module: `mont_modmul`

## Requirements
- R1: When `done` is high, `product` equals (A*B) mod M for the operands taken at the accepted start, given odd M, A < M, B < M and K = 2^(2W) mod M. With W = 6, the inputs A = 15, B = 26, M = 47 and K = 7 give 14.
- R2: Each pass runs W add/halve iterations and then subtracts M at most once. The delivered `product` is always below M.
- R3: `done` is high in the cycle that follows the 2+6W-th rising edge after the edge that accepted `start`. Each pass takes one load cycle and three cycles per iteration, and pass 0 hands over to pass 1 with no idle cycle.
- R4: `done` is high for exactly one cycle per accepted start.
- R5: `product` changes only at the edge that raises `done`. It holds its value in every other cycle.
- R6: While a product is being computed, `start` is ignored. A start raised during that time changes neither the timing nor the value of the pending result.
- R7: A, B, M and K are sampled only at the accepted start. Changing them later has no effect on the pending result.
- R8: After reset, `done` is low and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a product; accepted only when idle |
| a_in | input | W | Multiplicand, below M |
| b_in | input | W | Multiplier, below M |
| m_in | input | W | Odd modulus |
| k_in | input | W | Correction constant 2^(2W) mod M |
| product | output | W | Last computed A*B mod M |
| done | output | 1 | One-cycle pulse when `product` is updated |

## Verification
A fault in the iteration counter or the state sequence shows up at the ports as a `done` pulse that comes early, comes late or goes missing. The bench compares `done` against the model on every cycle, so this kind of fault is caught within one cycle of the expected pulse. A wrong multiplexer choice or a missed reduction leaves the timing correct and corrupts only the value. Such a fault appears in the very `done` cycle, either as a wrong residue or as a value at or above M. Faults in the handling of busy-time starts or operand sampling show up in the next result as a displaced pulse or the residue of the wrong operands.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_ADD   = 3'd2,
    ST_SHIFT = 3'd3,
    ST_TEST  = 3'd4,
    ST_HALT  = 3'd5
  } mont_state_e;
endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic capture,
  output logic load,
  output logic add_en,
  output logic shift_en,
  output logic pass,
  output logic pass0_end,
  output logic pass1_end
);
  import mont_pkg::*;
  localparam int CW = $clog2(W + 1);

  mont_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic pass_q;
  logic iter_left;

  assign iter_left = (cnt_q != '0);
  assign capture   = (state_q == ST_HALT) && start;
  assign load      = (state_q == ST_LOAD);
  assign add_en    = (state_q == ST_ADD);
  assign shift_en  = (state_q == ST_SHIFT);
  assign pass      = pass_q;
  assign pass0_end = (state_q == ST_TEST) && !iter_left && !pass_q;
  assign pass1_end = (state_q == ST_TEST) && !iter_left && pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      cnt_q   <= '0;
      pass_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_INIT:  state_q <= ST_HALT;
        ST_HALT:  if (start) begin
                    state_q <= ST_LOAD;
                    pass_q  <= 1'b0;
                  end
        ST_LOAD:  begin
                    cnt_q   <= CW'(W);
                    state_q <= ST_ADD;
                  end
        ST_ADD:   begin
                    cnt_q   <= cnt_q - 1'b1;
                    state_q <= ST_SHIFT;
                  end
        ST_SHIFT: state_q <= ST_TEST;
        ST_TEST:  begin
                    if (iter_left) state_q <= ST_ADD;
                    else if (!pass_q) begin
                      pass_q  <= 1'b1;
                      state_q <= ST_LOAD;
                    end else state_q <= ST_HALT;
                  end
        default:  state_q <= ST_INIT;
      endcase
    end
  end

  // R3: the iteration counter never exceeds the operand width
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(W));
  // R3: pass 0 hands over straight to the load of pass 1
  p_pass_switch_r3: assert property (@(posedge clk) disable iff (rst)
    pass0_end |=> (state_q == ST_LOAD) && pass_q);
  // R6: a start seen while busy leaves the sequence untouched
  p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADD) |=> (state_q == ST_SHIFT));
endmodule

// File: rtl/mont_core.sv
module mont_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         add_en,
  input  logic         shift_en,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] reduced
);
  localparam int RW = W + 1;
  localparam int SW = W + 2;

  // Single conditional subtraction from [0, 2M) into [0, M)
  function automatic logic [W-1:0] fold_once(input logic [RW-1:0] acc,
                                             input logic [W-1:0] m);
    logic [RW-1:0] m_ext;
    m_ext = {1'b0, m};
    if (acc >= m_ext) return W'(acc - m_ext);
    return W'(acc);
  endfunction

  logic [W-1:0]  x_sh;
  logic [W-1:0]  y_q;
  logic [W-1:0]  m_q;
  logic [RW-1:0] acc_q;
  logic [SW-1:0] sum_q;
  logic          x_bit;
  logic [SW-1:0] y_pick;
  logic [SW-1:0] m_pick;
  logic [SW-1:0] sum_fix;

  assign x_bit   = x_sh[0];
  assign y_pick  = x_bit    ? SW'(y_q) : '0;
  assign m_pick  = sum_q[0] ? SW'(m_q) : '0;
  assign sum_fix = sum_q + m_pick;
  assign reduced = fold_once(acc_q, m_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_sh  <= '0;
      y_q   <= '0;
      m_q   <= '0;
      acc_q <= '0;
      sum_q <= '0;
    end else if (load) begin
      x_sh  <= op_x;
      y_q   <= op_y;
      m_q   <= modulus;
      acc_q <= '0;
    end else if (add_en) begin
      sum_q <= SW'(acc_q) + y_pick;
    end else if (shift_en) begin
      acc_q <= sum_fix[SW-1:1];
      x_sh  <= x_sh >> 1;
    end
  end

  // R2: after a halving step the accumulator stays below twice the modulus
  p_acc_bound_r2: assert property (@(posedge clk) disable iff (rst)
    $past(shift_en) |-> (acc_q < {m_q, 1'b0}));
  // R2: the halved value is always exact, since the fixed sum is even
  p_even_sum_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> (sum_fix[0] == 1'b0));
endmodule

// File: rtl/mont_modmul.sv
module mont_modmul #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] m_in,
  input  logic [W-1:0] k_in,
  output logic [W-1:0] product,
  output logic         done
);
  logic capture, load, add_en, shift_en, pass, pass0_end, pass1_end;
  logic [W-1:0] a_q, b_q, m_q, k_q, p1_q, prod_q;
  logic [W-1:0] op_x, op_y, reduced;
  logic done_q;

  mont_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .capture(capture), .load(load), .add_en(add_en), .shift_en(shift_en),
    .pass(pass), .pass0_end(pass0_end), .pass1_end(pass1_end)
  );

  // Pass 0 multiplies the operands; pass 1 applies the correction constant
  assign op_x = pass ? p1_q : a_q;
  assign op_y = pass ? k_q  : b_q;

  mont_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load(load), .add_en(add_en), .shift_en(shift_en),
    .op_x(op_x), .op_y(op_y), .modulus(m_q), .reduced(reduced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; m_q <= '0; k_q <= '0;
      p1_q <= '0; prod_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= pass1_end;
      if (capture) begin
        a_q <= a_in; b_q <= b_in; m_q <= m_in; k_q <= k_in;
      end
      if (pass0_end) p1_q <= reduced;
      if (pass1_end) prod_q <= reduced;
    end
  end

  assign product = prod_q;
  assign done    = done_q;

  // R4: a single-cycle pulse
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: the delivered product is a proper residue
  p_result_below_mod_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (product < m_q));
  // R5: the product only moves with the done pulse
  p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
  // R7: operand copies stay frozen while a product is pending
  p_ops_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (add_en || shift_en) |=> $stable(m_q) && $stable(k_q));
endmodule

// File: tb/tb_mont_modmul.sv
module tb_mont_modmul;
  localparam int W = 6;
  localparam int LAT = 2 + 6 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, m_in = '0, k_in = '0;
  logic [W-1:0] product;
  logic done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  bit busy_m = 0;
  int cnt_m = 0;
  bit exp_done = 0;
  int exp_prod = 0;
  int pend_prod = 0;

  always #4 clk = ~clk;

  mont_modmul #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .a_in(a_in), .b_in(b_in), .m_in(m_in), .k_in(k_in),
    .product(product), .done(done)
  );

  function automatic int k_const(input int m);
    return (1 << (2 * W)) % m;
  endfunction

  always @(posedge clk) begin
    cycles++;
    exp_done = 0;
    if (rst) begin
      busy_m = 0; cnt_m = 0; exp_prod = 0;
    end else if (busy_m) begin
      cnt_m--;
      if (cnt_m == 0) begin
        busy_m = 0; exp_done = 1; exp_prod = pend_prod;
      end
    end else if (start && cycles > 3) begin
      busy_m = 1; cnt_m = LAT;
      pend_prod = (int'(a_in) * int'(b_in)) % int'(m_in);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // every-cycle comparison: R3/R4 timing of done, R1 value, R5 hold
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3/R4 done timing", int'(done), int'(exp_done));
      chk("R1/R5 product", int'(product), exp_prod);
      if (done) chk("R2 below modulus", int'(product < m_sel), 1);
    end
  end

  logic [W-1:0] m_sel = '1;

  task automatic run(input int a, input int b, input int m, input bit noise);
    @(negedge clk);
    a_in = W'(a); b_in = W'(b); m_in = W'(m); k_in = W'(k_const(m));
    m_sel = W'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: scramble the operands after acceptance
    a_in = W'(a + 1); b_in = '0; m_in = W'(m + 2); k_in = '1;
    repeat (LAT / 2) @(negedge clk);
    if (noise) begin
      // R6: start during the computation must be ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy_m) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset done", int'(done), 0);
    chk("R8 reset product", int'(product), 0);
    repeat (3) @(negedge clk);
    // R1: worked example 15*26 mod 47 = 14
    run(15, 26, 47, 0);
    chk("R1 example", int'(product), 14);
    run(0, 40, 47, 0);
    chk("R1 zero operand", int'(product), 0);
    run(46, 46, 47, 1);
    chk("R1 max operands", int'(product), 1);
    run(62, 61, 63, 1);
    chk("R1 top modulus", int'(product), (62 * 61) % 63);
    run(2, 1, 3, 0);
    chk("R1 small modulus", int'(product), 2);
    for (int i = 0; i < 40; i++) begin
      int m, a, b;
      m = 3 + 2 * int'($urandom_range(0, 30));
      a = int'($urandom_range(0, m - 1));
      b = int'($urandom_range(0, m - 1));
      run(a, b, m, i[0]);
      chk("R1 random", int'(product), (a * b) % m);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule